// File: doc/BRIEF.md
# Dual-Stage Strobe Divider

This block turns a stream of reference ticks into a slower stream of one-cycle enable strobes, all in the reference clock domain. Two integer stages run in cascade, and each divides by a programmable value from 1 to 8. A third, optional stage divides by two and a half. It does this by letting through two of every five pulses that leave the integer stages, so over the long run the rate is exact. Logic elsewhere in the same clock domain uses the strobe as a clock enable. The block does not make a real clock with a 50% duty cycle.

Software programs the block through a single control word, written through a simple write port. The word holds both stage fields, the predivide select and an output enable. A write has to be safe while the output is running. While the block is enabled, a new word is held back until the next output strobe, so no period is ever cut short. While the block is disabled, a new word is applied at once and all counting starts again from zero.

Top module: `dual_div_strobe`

## Requirements
- R1: After reset the control word is all zero, so the block is disabled, `strobe_o` is 0, and no strobe appears until a word with the enable bit set is written.
- R2: Bits [2:0] hold the first divisor minus one and bits [5:3] hold the second divisor minus one. With predivide clear, one strobe is produced per (a+1)*(b+1) reference ticks, where a and b are the two field values. The largest ratio is 64.
- R3: With both fields 0, predivide clear and `tick_i` high on every cycle, `strobe_o` is high on every cycle while the block is enabled.
- R4: Bit 6 selects the divide-by-2.5 stage. After an enabling write, strobes follow the integer-stage period N at gaps of N, then 2N, 3N, 2N, 3N and so on.
- R5: Bit 7 is the enable. While the active word has it clear, no strobe is produced. A write made while disabled takes effect on the next clock edge, and counting restarts from zero.
- R6: A write made while enabled leaves the current period unchanged. It becomes active at the next strobe, and the period that follows uses the new ratio.
- R7: Counting advances only on cycles where `tick_i` is high. The strobe is registered and rises one cycle after the tick that completes a period.
- R8: A write that clears the enable while the block is running still lets the current period finish with one strobe. After that strobe, no further strobes appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Reference tick qualifier; counting advances when high |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_wdata_i | input | 8 | Control word: [7] enable, [6] predivide, [5:3] second field, [2:0] first field |
| strobe_o | output | 1 | One-cycle divided enable strobe |

## Verification
The bench measures the gaps between strobes. It targets the all-zero fields, which must give a strobe on every cycle (a design with an off-by-one compare would skip every other cycle), and the largest ratio of 64, which exposes a counter that is too narrow or wraps early. For the 2.5 stage it checks the exact 2N/3N alternation; a wrong phase decode would give even gaps or the wrong count per five pulses. The reprogramming tests write a new word in the middle of a period and expect the old gap to finish, which catches designs that apply the word at once and leave a runt period, and they confirm that a disabling write still lets one final strobe through.

// File: rtl/dds_pkg.sv
package dds_pkg;
    localparam int FIELD_W = 3;
    localparam int CFG_W   = 2 * FIELD_W + 2;
    localparam int PH_W    = 3;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(4);

    typedef struct packed {
        logic               en;
        logic               pre;
        logic [FIELD_W-1:0] div_b;
        logic [FIELD_W-1:0] div_a;
    } ctl_word_t;

    function automatic ctl_word_t to_ctl(input logic [CFG_W-1:0] raw);
        return ctl_word_t'(raw);
    endfunction

    // fractional stage emits on these phases of a 5-pulse cycle
    function automatic logic frac_emit(input logic [PH_W-1:0] ph);
        return (ph == PH_W'(0)) || (ph == PH_W'(2));
    endfunction
endpackage

// File: rtl/dds_stage.sv
module dds_stage
    import dds_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               clr_i,
    input  logic               adv_i,
    input  logic [FIELD_W-1:0] limit_i,
    output logic               wrap_o
);
    logic [FIELD_W-1:0] cnt_q;

    assign wrap_o = adv_i && (cnt_q == limit_i);

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            cnt_q <= '0;
        end else if (adv_i) begin
            cnt_q <= wrap_o ? '0 : cnt_q + FIELD_W'(1);
        end
    end

    p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q <= limit_i);
endmodule

// File: rtl/dds_frac.sv
module dds_frac
    import dds_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            clr_i,
    input  logic [PH_W-1:0] start_i,
    input  logic            adv_i,
    input  logic            bypass_i,
    output logic            fire_o
);
    logic [PH_W-1:0] ph_q;

    assign fire_o = adv_i && (bypass_i || frac_emit(ph_q));

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ph_q <= '0;
        end else if (clr_i) begin
            ph_q <= start_i;
        end else if (adv_i && !bypass_i) begin
            ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + PH_W'(1);
        end
    end

    p_phase_range_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        ph_q <= PH_LAST);
endmodule

// File: rtl/dds_ctrl.sv
module dds_ctrl
    import dds_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             we_i,
    input  logic [CFG_W-1:0] wdata_i,
    input  logic             boundary_i,
    output ctl_word_t        act_o,
    output logic             clr_o,
    output logic [PH_W-1:0]  start_o
);
    ctl_word_t act_q, pend_q;
    logic      pend_v_q;
    logic      load_idle, load_edge;

    assign load_idle = we_i && !act_q.en;
    assign load_edge = boundary_i && (we_i || pend_v_q);
    assign clr_o     = load_idle || load_edge;
    assign start_o   = load_edge ? PH_W'(1) : PH_W'(0);
    assign act_o     = act_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            act_q    <= '0;
            pend_q   <= '0;
            pend_v_q <= 1'b0;
        end else if (load_idle) begin
            act_q    <= to_ctl(wdata_i);
            pend_v_q <= 1'b0;
        end else if (boundary_i) begin
            if (we_i)          act_q <= to_ctl(wdata_i);
            else if (pend_v_q) act_q <= pend_q;
            pend_v_q <= 1'b0;
        end else if (we_i) begin
            pend_q   <= to_ctl(wdata_i);
            pend_v_q <= 1'b1;
        end
    end

    p_hold_word_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (act_q.en && !boundary_i) |=> $stable(act_q));
    p_pend_drain_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        boundary_i |=> !pend_v_q);
endmodule

// File: rtl/dual_div_strobe.sv
module dual_div_strobe
    import dds_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             tick_i,
    input  logic             cfg_we_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    output logic             strobe_o
);
    localparam int NSTAGE = 2;

    ctl_word_t          act;
    logic               clr;
    logic [PH_W-1:0]    start_ph;
    logic               fire;
    logic               strobe_q;
    logic [NSTAGE:0]    chain;
    logic [FIELD_W-1:0] limits [NSTAGE];

    assign limits[0] = act.div_a;
    assign limits[1] = act.div_b;
    assign chain[0]  = tick_i && act.en;

    dds_ctrl u_ctrl (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .we_i       (cfg_we_i),
        .wdata_i    (cfg_wdata_i),
        .boundary_i (fire),
        .act_o      (act),
        .clr_o      (clr),
        .start_o    (start_ph)
    );

    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        dds_stage u_stage (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .clr_i   (clr),
            .adv_i   (chain[g]),
            .limit_i (limits[g]),
            .wrap_o  (chain[g+1])
        );
    end

    dds_frac u_frac (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .clr_i    (clr),
        .start_i  (start_ph),
        .adv_i    (chain[NSTAGE]),
        .bypass_i (!act.pre),
        .fire_o   (fire)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) strobe_q <= 1'b0;
        else       strobe_q <= fire;
    end

    assign strobe_o = strobe_q;

    p_off_quiet_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        !act.en |=> !strobe_o);
    p_every_cycle_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (act.en && !act.pre && act.div_a == '0 && act.div_b == '0 && tick_i) |=> strobe_o);
    p_no_tick_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        !tick_i |=> !strobe_o);
endmodule

// File: tb/dual_div_strobe_tb_top.sv
module dual_div_strobe_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b1;
    logic       we = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       strobe;
    int         tick_mode = 0;
    int         n_chk = 0;
    int         n_bad = 0;

    always #4 clk = ~clk;

    always @(negedge clk) begin
        if (tick_mode == 0)      tick <= 1'b1;
        else if (tick_mode == 1) tick <= ~tick;
        else                     tick <= 1'b0;
    end

    dual_div_strobe dut_i (
        .clk_i       (clk),
        .rst_i       (rst),
        .tick_i      (tick),
        .cfg_we_i    (we),
        .cfg_wdata_i (wdata),
        .strobe_o    (strobe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; we = 1'b0; tick_mode = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr_cfg(input logic [7:0] d);
        we = 1'b1; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic next_gap(output int g);
        g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!strobe && g < 2000);
    endtask

    task automatic count_strobes(input int n, output int c);
        c = 0;
        repeat (n) begin
            @(negedge clk);
            if (strobe) c++;
        end
    endtask

    task automatic t_reset_r1();
        int c;
        do_reset();
        check(strobe == 1'b0, "R1 reset strobe", strobe, 0);
        count_strobes(100, c);
        check(c == 0, "R1 idle after reset", c, 0);
    endtask

    task automatic t_ratio_r2(input logic [7:0] d, input int n);
        int g;
        do_reset();
        wr_cfg(d);
        for (int i = 0; i < 4; i++) begin
            next_gap(g);
            check(g == n, "R2 integer ratio gap", g, n);
        end
    endtask

    task automatic t_fast_r3();
        int c;
        do_reset();
        wr_cfg(8'h80);
        count_strobes(20, c);
        check(c == 20, "R3 strobe every cycle", c, 20);
    endtask

    task automatic t_pre_r4();
        int g;
        int exp [5] = '{2, 4, 6, 4, 6};
        do_reset();
        wr_cfg(8'hC1);
        for (int i = 0; i < 5; i++) begin
            next_gap(g);
            check(g == exp[i], "R4 predivide gap", g, exp[i]);
        end
    endtask

    task automatic t_enable_r5();
        int c, g;
        do_reset();
        wr_cfg(8'h1A);
        count_strobes(100, c);
        check(c == 0, "R5 disabled word quiet", c, 0);
        wr_cfg(8'h81);
        next_gap(g);
        check(g == 2, "R5 immediate apply when idle", g, 2);
    endtask

    task automatic t_reprog_r6();
        int g;
        do_reset();
        wr_cfg(8'h87);
        next_gap(g);
        check(g == 8, "R6 first period", g, 8);
        repeat (3) @(negedge clk);
        wr_cfg(8'h81);
        next_gap(g);
        check(g == 4, "R6 old period completes", g + 4, 8);
        next_gap(g);
        check(g == 2, "R6 new ratio after boundary", g, 2);
        next_gap(g);
        check(g == 2, "R6 new ratio steady", g, 2);
    endtask

    task automatic t_tick_r7();
        int g, c;
        do_reset();
        tick_mode = 1;
        wr_cfg(8'h82);
        next_gap(g);
        for (int i = 0; i < 3; i++) begin
            next_gap(g);
            check(g == 6, "R7 half-rate ticks", g, 6);
        end
        tick_mode = 2;
        @(negedge clk);
        count_strobes(50, c);
        check(c == 0, "R7 no ticks no strobes", c, 0);
        tick_mode = 0;
    endtask

    task automatic t_disable_r8();
        int g, c;
        do_reset();
        wr_cfg(8'h83);
        next_gap(g);
        check(g == 4, "R8 running period", g, 4);
        @(negedge clk);
        wr_cfg(8'h00);
        next_gap(g);
        check(g == 2, "R8 final strobe kept", g + 2, 4);
        count_strobes(100, c);
        check(c == 0, "R8 quiet after disable", c, 0);
    endtask

    initial begin
        t_reset_r1();
        t_ratio_r2(8'h9A, 12);
        t_ratio_r2(8'hA0, 5);
        t_ratio_r2(8'hBF, 64);
        t_fast_r3();
        t_pre_r4();
        t_enable_r5();
        t_reprog_r6();
        t_tick_r7();
        t_disable_r8();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog (all R) actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule